// File: doc/BRIEF.md
# Bit-Addressed Serial-Input Latch Bank

This block holds a small bank of storage bits that are written one bit at a time. A binary address picks the bit, a single serial data line supplies its new value, and a strobe qualifies the write. Every stored bit is presented together on a parallel bus. That bus is three-stated by an active-low output enable, so the bank can sit on a shared processor data bus and be read like any other bus device.

The design is synchronous. One system clock samples the strobe, the address, the data and the reset. A write becomes visible on the bus right after the clock edge that saw the strobe high. The bank size follows from the address width parameter, and a second parameter picks how the address decoder is built.

Top module: `lbk_top`

## Requirements
- R1: The address value n, read as an unsigned binary number with `addr_i[ADDR_W-1]` as the most significant bit, selects bit n of the bank. Bit n appears on `bus_o[n]`.
- R2: When `strobe_i` is 1 and `rst_i` is 0 at a rising clock edge, the addressed bit takes the value of `din_i`. The new value is on the bus from that edge on.
- R3: During a write, every bit other than the addressed one keeps its stored value.
- R4: When `strobe_i` is 0 at a rising clock edge, no stored bit changes.
- R5: When `rst_i` is 1 at a rising clock edge, every stored bit becomes 0. This holds whatever the strobe, address and data are, and it takes priority over a write in the same cycle.
- R6: While `oe_n_i` is 0, `bus_o` carries all stored bits in parallel.
- R7: While `oe_n_i` is 1, every bit of `bus_o` is high impedance. Another driver on the same net then fully sets the bus value.
- R8: `oe_n_i` controls only the bus drivers. Writes made while it is 1 still take effect, and toggling it never alters stored bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_i | input | 1 | Synchronous active-high clear of the whole bank |
| strobe_i | input | 1 | Write qualifier, active high |
| addr_i | input | ADDR_W | Binary index of the bit to write |
| din_i | input | 1 | Serial data value for the addressed bit |
| oe_n_i | input | 1 | Active-low enable for the bus drivers |
| bus_o | output | 2**ADDR_W | Three-state parallel read-out of the bank |

## Verification
The assertions assume that the strobe, address, data and reset hold steady across each rising clock edge. This is the synchronous form of the setup and hold window around the strobe. They also assume that nothing else drives the bus while the enable is low. The stimulus changes every input just after a falling edge. The bench drives its own probe patterns onto the shared bus net only while the enable is high, and it releases that net before the next rising edge.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
   // Decoder build variants for the write-select logic.
   typedef enum logic [0:0] {
      DEC_COMPARE = 1'b0,   // one equality comparator per bit
      DEC_SHIFT   = 1'b1    // single barrel shift of a one
   } dec_style_e;

   localparam int unsigned MAX_ADDR_W = 8;
endpackage

// File: rtl/lbk_addr_decode.sv
module lbk_addr_decode
   import lbk_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter dec_style_e  DEC_STYLE = DEC_COMPARE,
   localparam int unsigned NBITS    = 1 << ADDR_W
) (
   input  logic              strobe_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NBITS-1:0]  sel_o
);
   generate
      if (DEC_STYLE == DEC_COMPARE) begin : g_cmp
         for (genvar i = 0; i < NBITS; i++) begin : g_bit
            assign sel_o[i] = strobe_i && (addr_i == ADDR_W'(i));
         end
      end else begin : g_shift
         assign sel_o = strobe_i ? (NBITS'(1) << addr_i) : '0;
      end
   endgenerate
endmodule

// File: rtl/lbk_bit_cell.sv
module lbk_bit_cell (
   input  logic clk_i,
   input  logic rst_i,
   input  logic wr_en_i,
   input  logic din_i,
   output logic q_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i)        q_o <= 1'b0;
      else if (wr_en_i) q_o <= din_i;
   end
endmodule

// File: rtl/lbk_top.sv
module lbk_top
   import lbk_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter dec_style_e  DEC_STYLE = DEC_COMPARE,
   localparam int unsigned NBITS    = 1 << ADDR_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              strobe_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              din_i,
   input  logic              oe_n_i,
   output logic [NBITS-1:0]  bus_o
);
   generate
      if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_width
         $error("lbk_top: ADDR_W must lie in 1..%0d", MAX_ADDR_W);
      end
   endgenerate

   logic [NBITS-1:0] sel;
   logic [NBITS-1:0] store_q;

   lbk_addr_decode #(
      .ADDR_W   (ADDR_W),
      .DEC_STYLE(DEC_STYLE)
   ) dec_i (
      .strobe_i(strobe_i),
      .addr_i  (addr_i),
      .sel_o   (sel)
   );

   generate
      for (genvar b = 0; b < NBITS; b++) begin : g_cell
         lbk_bit_cell cell_i (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .wr_en_i(sel[b]),
            .din_i  (din_i),
            .q_o    (store_q[b])
         );
      end
   endgenerate

   // Three-state bus drivers: enable is active low.
   assign bus_o = oe_n_i ? {NBITS{1'bz}} : store_q;
endmodule

// File: rtl/lbk_chk.sv
module lbk_chk #(
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned NBITS = 1 << ADDR_W
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              strobe_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              din_i,
   input logic              oe_n_i,
   input logic [NBITS-1:0]  bus_o,
   input logic [NBITS-1:0]  store_q
);
   // R1 / R2: addressed bit takes the data value
   a_r2_write_lands: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_i |=> store_q[$past(addr_i)] == $past(din_i));

   // R3: neighbours of the addressed bit are untouched
   a_r3_others_kept: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_i |=> ((store_q ^ $past(store_q)) & ~(NBITS'(1) << $past(addr_i))) == '0);

   // R4: idle strobe freezes the bank
   a_r4_idle_stable: assert property (@(posedge clk_i) disable iff (rst_i)
      !strobe_i |=> $stable(store_q));

   // R5: reset clears everything next cycle, even with a write pending
   a_r5_reset_clears: assert property (@(posedge clk_i)
      rst_i |=> store_q == '0);

   // R6: enabled bus mirrors the bank
   a_r6_bus_mirrors: assert property (@(posedge clk_i) disable iff (rst_i)
      !oe_n_i |-> bus_o == store_q);

   // R8: enable activity alone never moves the stored bits
   a_r8_oe_no_effect: assert property (@(posedge clk_i) disable iff (rst_i)
      (!strobe_i && $changed(oe_n_i)) |=> $stable(store_q));
endmodule

bind lbk_top lbk_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .strobe_i(strobe_i),
   .addr_i  (addr_i),
   .din_i   (din_i),
   .oe_n_i  (oe_n_i),
   .bus_o   (bus_o),
   .store_q (store_q)
);

// File: tb/lbk_top_tb_top.sv
module lbk_top_tb_top;
   localparam int unsigned AW = 3;
   localparam int unsigned NB = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          stb = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          din = 1'b0;
   logic          oe_n = 1'b0;
   logic          tb_en = 1'b0;
   logic [NB-1:0] tb_pat = '0;
   wire  [NB-1:0] bus;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   assign bus = tb_en ? tb_pat : {NB{1'bz}};

   always #5 clk = ~clk;

   lbk_top #(.ADDR_W(AW)) dut_i (
      .clk_i   (clk),
      .rst_i   (rst),
      .strobe_i(stb),
      .addr_i  (addr),
      .din_i   (din),
      .oe_n_i  (oe_n),
      .bus_o   (bus)
   );

   // Vector: [14] rst [13] strobe [12] oe_n [11:9] addr [8] din [7:0] expected bank
   localparam int NV = 10;
   localparam logic [14:0] VEC [NV] = '{
      {1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00},  // R5 reset state
      {1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 8'h01},  // R2 lowest address
      {1'b0, 1'b1, 1'b0, 3'd7, 1'b1, 8'h81},  // R1 top address, msb
      {1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 8'h89},  // R2
      {1'b0, 1'b1, 1'b0, 3'd3, 1'b0, 8'h81},  // R3 clear one bit only
      {1'b0, 1'b0, 1'b0, 3'd5, 1'b1, 8'h81},  // R4 strobe low ignored
      {1'b0, 1'b1, 1'b1, 3'd5, 1'b1, 8'hA1},  // R8 write while disabled, R7
      {1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 8'hA1},  // R7 still floating
      {1'b0, 1'b0, 1'b0, 3'd2, 1'b1, 8'hA1},  // R8 hidden write read back
      {1'b1, 1'b1, 1'b0, 3'd2, 1'b1, 8'h00}   // R5 reset beats write
   };

   task automatic check_bus(input logic [NB-1:0] exp, input string req);
      checks++;
      if (bus !== exp) begin
         fails++;
         $display("FAIL %s: bus actual %h expected %h", req, bus, exp);
      end
   endtask

   // Prove high impedance by overdriving the net with two opposite patterns.
   task automatic probe_z(input string req);
      tb_pat = '0;
      tb_en  = 1'b1;
      #1 check_bus('0, req);
      tb_pat = '1;
      #1 check_bus('1, req);
      tb_en  = 1'b0;
   endtask

   task automatic step(input logic r, input logic s, input logic o,
                       input logic [AW-1:0] a, input logic d);
      rst = r; stb = s; oe_n = o; addr = a; din = d;
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1 check_bus('0, "R5");
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
         if (VEC[i][12]) probe_z("R7");
         else            check_bus(VEC[i][7:0], "R6");
      end
      // R1: each address drives exactly its own bus bit
      for (int a = 0; a < NB; a++) begin
         step(1'b0, 1'b1, 1'b0, AW'(a), 1'b1);
         check_bus(NB'(1) << a, "R1");
         step(1'b0, 1'b1, 1'b0, AW'(a), 1'b0);
         check_bus('0, "R3");
      end
      // R3: fill, then clear a single bit
      for (int a = 0; a < NB; a++) step(1'b0, 1'b1, 1'b0, AW'(a), 1'b1);
      check_bus('1, "R2");
      step(1'b0, 1'b1, 1'b0, 3'd5, 1'b0);
      check_bus(8'hDF, "R3");
      // R8: enable toggling with idle strobe keeps contents
      step(1'b0, 1'b0, 1'b1, 3'd0, 1'b0);
      probe_z("R7");
      step(1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
      check_bus(8'hDF, "R8");
      // R4: data and address wiggle with strobe low
      step(1'b0, 1'b0, 1'b0, 3'd5, 1'b1);
      check_bus(8'hDF, "R4");
      step(1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
      check_bus('0, "R5");
      rst = 1'b0;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule